// File: doc/BRIEF.md
# Sequential Nonrestoring Unsigned Divider

This block divides one unsigned WIDTH-bit integer by another over several clock cycles and returns a WIDTH-bit quotient and a WIDTH-bit remainder. A one-cycle start strobe, sampled while the block is idle, captures both operands. The block then produces one quotient bit per cycle. Each cycle it shifts a combined partial-remainder/dividend pair left by one bit, then adds or subtracts the divisor. The choice depends on the sign the partial remainder had before the shift, so the loop never restores a step. The partial remainder is kept in two's complement and is one bit wider than the operands, so no step can overflow.

After the last quotient bit there is a single fix-up cycle. If the partial remainder is negative, this cycle adds the divisor back once. A one-cycle done pulse then marks the results as valid. A zero divisor does not run the loop: the block raises an error flag and finishes at once with fixed results.

Top module: `nr_divider`

## Requirements
- R1: After reset, busyOut, doneOut and divZeroOut are 0, and quotientOut and remainderOut are all zeros.
- R2: A start accepted while idle sets busyOut to 1 from the next cycle on. busyOut stays 1 until the done cycle ends.
- R3: For a nonzero divisor d and a dividend n, the outputs at done give quotientOut*d + remainderOut == n and remainderOut < d.
- R4: For a nonzero divisor, doneOut is first high WIDTH+1 clock edges after the edge that accepted the start.
- R5: doneOut is high for exactly one cycle, and busyOut is 0 in the cycle after it.
- R6: startIn is ignored while busyOut is 1, including during the done cycle. A start seen then neither changes the results in flight nor begins a new division.
- R7: For a zero divisor, doneOut is high right after the accepting edge and divZeroOut is 1. quotientOut is all ones and remainderOut equals the dividend.
- R8: divZeroOut is 0 at the done of every division whose divisor is nonzero.
- R9: While the block is idle and no start arrives, quotientOut, remainderOut and divZeroOut keep their values, whatever the operand inputs do.
- R10: Boundary operands give exact results. A dividend smaller than the divisor gives quotient 0 and remainder equal to the dividend. Division by 1 returns the dividend with remainder 0. All-ones divided by all-ones gives 1 remainder 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| startIn | input | 1 | Start strobe, accepted only while idle |
| dividendIn | input | WIDTH | Dividend, sampled on accepted start |
| divisorIn | input | WIDTH | Divisor, sampled on accepted start |
| busyOut | output | 1 | High from the cycle after acceptance through the done cycle |
| doneOut | output | 1 | One-cycle completion pulse |
| quotientOut | output | WIDTH | Quotient, valid from done until the next accepted start |
| remainderOut | output | WIDTH | Remainder, valid from done until the next accepted start |
| divZeroOut | output | 1 | Set at done when the divisor was zero |

## Verification
The bench builds the block with WIDTH = 8. At that width the iteration counter wraps over three bits, and a full-scale dividend like 255 makes the partial remainder swing negative and back many times. Several hundred pseudo-random operand pairs, plus the all-ones and unit corners, reach both the add and the subtract path in every iteration position. They also reach the final fix-up with a negative and with a nonnegative remainder. The latency check at this width confirms that exactly eight iterations plus one fix-up cycle happen before done.

// File: rtl/nr_div_pkg.sv
package nr_div_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2,
    ST_DONE = 2'd3
  } divState_t;

  // Strobes from control to datapath; at most one is high per cycle.
  typedef struct packed {
    logic load;      // capture operands, clear partial remainder
    logic loadZero;  // capture the fixed zero-divisor result
    logic step;      // one shift plus add/subtract iteration
    logic fix;       // final remainder correction
  } divCtrl_t;

endpackage

// File: rtl/nr_div_ctrl.sv
module nr_div_ctrl
  import nr_div_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     startIn,
  input  logic     divisorZero,
  output divCtrl_t ctrlOut,
  output logic     busyOut,
  output logic     doneOut
);

  localparam int CW = (WIDTH > 2) ? $clog2(WIDTH) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  divState_t stateQ, stateD;
  logic [CW-1:0] iterQ;

  always_comb begin
    stateD  = stateQ;
    ctrlOut = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (startIn) begin
          if (divisorZero) begin
            ctrlOut.loadZero = 1'b1;
            stateD = ST_DONE;
          end else begin
            ctrlOut.load = 1'b1;
            stateD = ST_RUN;
          end
        end
      end
      ST_RUN: begin
        ctrlOut.step = 1'b1;
        if (iterQ == LAST) stateD = ST_FIX;
      end
      ST_FIX: begin
        ctrlOut.fix = 1'b1;
        stateD = ST_DONE;
      end
      ST_DONE: stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      iterQ  <= '0;
    end else begin
      stateQ <= stateD;
      if (ctrlOut.load)      iterQ <= '0;
      else if (ctrlOut.step) iterQ <= iterQ + 1'b1;
    end
  end

  assign busyOut = (stateQ != ST_IDLE);
  assign doneOut = (stateQ == ST_DONE);

endmodule

// File: rtl/nr_div_datapath.sv
module nr_div_datapath
  import nr_div_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  divCtrl_t         ctrlIn,
  input  logic [WIDTH-1:0] dividendIn,
  input  logic [WIDTH-1:0] divisorIn,
  output logic             divisorZero,
  output logic [WIDTH-1:0] quotientOut,
  output logic [WIDTH-1:0] remainderOut,
  output logic             divZeroOut
);

  localparam int PW = WIDTH + 1;

  logic [PW-1:0]    pReg;       // two's complement partial remainder
  logic [WIDTH-1:0] aReg;       // dividend shifting out, quotient shifting in
  logic [WIDTH-1:0] bReg;       // divisor
  logic             zeroFlag;

  logic             pNeg;
  logic [PW-1:0]    bExt, pShift, pNext, pFixed;

  always_comb begin
    pNeg   = pReg[PW-1];
    bExt   = {1'b0, bReg};
    pShift = {pReg[PW-2:0], aReg[WIDTH-1]};
    pNext  = pNeg ? (pShift + bExt) : (pShift - bExt);
    pFixed = pNeg ? (pReg + bExt) : pReg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pReg     <= '0;
      aReg     <= '0;
      bReg     <= '0;
      zeroFlag <= 1'b0;
    end else if (ctrlIn.load) begin
      pReg     <= '0;
      aReg     <= dividendIn;
      bReg     <= divisorIn;
      zeroFlag <= 1'b0;
    end else if (ctrlIn.loadZero) begin
      pReg     <= {1'b0, dividendIn};
      aReg     <= '1;
      bReg     <= divisorIn;
      zeroFlag <= 1'b1;
    end else if (ctrlIn.step) begin
      pReg <= pNext;
      aReg <= {aReg[WIDTH-2:0], ~pNext[PW-1]};
    end else if (ctrlIn.fix) begin
      pReg <= pFixed;
    end
  end

  assign divisorZero  = (divisorIn == '0);
  assign quotientOut  = aReg;
  assign remainderOut = pReg[WIDTH-1:0];
  assign divZeroOut   = zeroFlag;

endmodule

// File: rtl/nr_divider.sv
module nr_divider
  import nr_div_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startIn,
  input  logic [WIDTH-1:0] dividendIn,
  input  logic [WIDTH-1:0] divisorIn,
  output logic             busyOut,
  output logic             doneOut,
  output logic [WIDTH-1:0] quotientOut,
  output logic [WIDTH-1:0] remainderOut,
  output logic             divZeroOut
);

  divCtrl_t ctrl;
  logic     divisorZero;

  nr_div_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startIn    (startIn),
    .divisorZero(divisorZero),
    .ctrlOut    (ctrl),
    .busyOut    (busyOut),
    .doneOut    (doneOut)
  );

  nr_div_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctrlIn      (ctrl),
    .dividendIn  (dividendIn),
    .divisorIn   (divisorIn),
    .divisorZero (divisorZero),
    .quotientOut (quotientOut),
    .remainderOut(remainderOut),
    .divZeroOut  (divZeroOut)
  );

endmodule

// File: rtl/nr_divider_checker.sv
module nr_divider_checker #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             startIn,
  input logic [WIDTH-1:0] dividendIn,
  input logic [WIDTH-1:0] divisorIn,
  input logic             busyOut,
  input logic             doneOut,
  input logic [WIDTH-1:0] quotientOut,
  input logic [WIDTH-1:0] remainderOut,
  input logic             divZeroOut
);

  localparam int DW = 2 * WIDTH;
  localparam int LW = $clog2(WIDTH + 3) + 1;

  logic [WIDTH-1:0] ddLat, dvLat;
  logic [LW-1:0]    lat;
  logic [DW-1:0]    recon;
  logic             accept;

  assign accept = startIn && !busyOut;
  assign recon  = ({{WIDTH{1'b0}}, quotientOut} * {{WIDTH{1'b0}}, dvLat})
                + {{WIDTH{1'b0}}, remainderOut};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ddLat <= '0;
      dvLat <= '0;
      lat   <= '0;
    end else if (accept) begin
      ddLat <= dividendIn;
      dvLat <= divisorIn;
      lat   <= '0;
    end else if (busyOut && lat != '1) begin
      lat <= lat + 1'b1;
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rstN |=> (!busyOut && !doneOut && !divZeroOut));

  assert_busy_after_start_R2: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> busyOut);

  assert_busy_held_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busyOut && !doneOut) |=> busyOut);

  assert_identity_R3: assert property (@(posedge clk) disable iff (!rstN)
    (doneOut && !divZeroOut) |-> (recon == {{WIDTH{1'b0}}, ddLat} && remainderOut < dvLat));

  assert_latency_R4: assert property (@(posedge clk) disable iff (!rstN)
    (doneOut && !divZeroOut) |-> (lat == LW'(WIDTH + 1)));

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> (!doneOut && !busyOut));

  assert_no_restart_R6: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !busyOut);

  assert_zero_result_R7: assert property (@(posedge clk) disable iff (!rstN)
    (doneOut && divZeroOut) |-> (lat == '0 && quotientOut == '1 && remainderOut == ddLat));

  assert_flag_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    (doneOut && dvLat != '0) |-> !divZeroOut);

  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!busyOut && !startIn) |=> ($stable(quotientOut) && $stable(remainderOut) && $stable(divZeroOut)));

endmodule

bind nr_divider nr_divider_checker #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/nr_divider_bench.sv
module nr_divider_bench;

  localparam int  WIDTH = 8;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG = 150000;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             startIn = 1'b0;
  logic [WIDTH-1:0] dividendIn = '0;
  logic [WIDTH-1:0] divisorIn = '0;
  logic             busyOut, doneOut, divZeroOut;
  logic [WIDTH-1:0] quotientOut, remainderOut;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  logic [15:0] lfsr = 16'hACE1;

  nr_divider #(.WIDTH(WIDTH)) u_nr_divider (
    .clk(clk), .rstN(rstN), .startIn(startIn),
    .dividendIn(dividendIn), .divisorIn(divisorIn),
    .busyOut(busyOut), .doneOut(doneOut),
    .quotientOut(quotientOut), .remainderOut(remainderOut),
    .divZeroOut(divZeroOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual %0d cycles, expected fewer than %0d", cycles, WATCHDOG);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
      $finish;
    end
  end

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Issue one start and wait for done; returns edges counted after acceptance.
  task automatic launch(input logic [WIDTH-1:0] dd, input logic [WIDTH-1:0] dv, output int lat);
    @(negedge clk);
    startIn = 1'b1; dividendIn = dd; divisorIn = dv;
    @(negedge clk);
    startIn = 1'b0;
    lat = 0;
    while (!doneOut && lat < 100) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic divide(input logic [WIDTH-1:0] dd, input logic [WIDTH-1:0] dv,
                        input string req, input bit checkLat);
    int lat;
    launch(dd, dv, lat);
    check({req, " quotient"}, quotientOut, dd / dv);
    check({req, " remainder"}, remainderOut, dd % dv);
    if (checkLat) begin
      check("R4 latency", lat, WIDTH + 1);
      check("R8 flag low", divZeroOut, 0);
    end
  endtask

  task automatic testReset();
    @(negedge clk);
    check("R1 busy", busyOut, 0);
    check("R1 done", doneOut, 0);
    check("R1 flag", divZeroOut, 0);
    check("R1 quotient", quotientOut, 0);
    check("R1 remainder", remainderOut, 0);
  endtask

  task automatic testBusyPulse();
    int lat;
    @(negedge clk);
    startIn = 1'b1; dividendIn = 8'd100; divisorIn = 8'd7;
    @(negedge clk);
    startIn = 1'b0;
    check("R2 busy after start", busyOut, 1);
    lat = 0;
    while (!doneOut && lat < 100) begin
      @(negedge clk);
      check("R2 busy held", busyOut, 1);
      lat++;
    end
    check("R5 done high", doneOut, 1);
    @(negedge clk);
    check("R5 done one cycle", doneOut, 0);
    check("R5 busy dropped", busyOut, 0);
  endtask

  task automatic testIgnoreStart();
    int lat;
    @(negedge clk);
    startIn = 1'b1; dividendIn = 8'd200; divisorIn = 8'd9;
    @(negedge clk);
    // R6: hold start high with other operands through the whole run and done
    dividendIn = 8'd17; divisorIn = 8'd0;
    lat = 0;
    while (!doneOut && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    check("R6 quotient unchanged", quotientOut, 200 / 9);
    check("R6 remainder unchanged", remainderOut, 200 % 9);
    check("R6 flag unchanged", divZeroOut, 0);
    startIn = 1'b0;
    @(negedge clk);
    check("R6 no restart after done", busyOut, 0);
    @(negedge clk);
    check("R6 still idle", busyOut, 0);
  endtask

  task automatic testZero();
    int lat;
    launch(8'd173, 8'd0, lat);
    check("R7 immediate done", lat, 0);
    check("R7 flag", divZeroOut, 1);
    check("R7 quotient all ones", quotientOut, 255);
    check("R7 remainder is dividend", remainderOut, 173);
    divide(8'd50, 8'd6, "R8 after zero", 1'b1);
  endtask

  task automatic testHold();
    logic [WIDTH-1:0] q, r;
    divide(8'd233, 8'd10, "R3 pre-hold", 1'b0);
    q = quotientOut; r = remainderOut;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      dividendIn = WIDTH'(i * 37); divisorIn = WIDTH'(i);
    end
    check("R9 quotient held", quotientOut, q);
    check("R9 remainder held", remainderOut, r);
    check("R9 flag held", divZeroOut, 0);
  endtask

  task automatic testBoundary();
    divide(8'd5,   8'd200, "R10 small dividend", 1'b1);
    divide(8'd255, 8'd1,   "R10 divide by one", 1'b1);
    divide(8'd255, 8'd255, "R10 max by max", 1'b1);
    divide(8'd0,   8'd3,   "R10 zero dividend", 1'b1);
    divide(8'd128, 8'd128, "R10 equal", 1'b1);
    divide(8'd254, 8'd255, "R10 just below", 1'b1);
  endtask

  task automatic testRandom();
    logic [WIDTH-1:0] dd, dv;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      dd = lfsr[7:0];
      dv = lfsr[15:8];
      if (i % 3 == 0) dv = dv >> 4;
      if (dv == '0) dv = 8'd1;
      divide(dd, dv, "R3 random", (i % 50) == 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testBusyPulse();
    testIgnoreStart();
    testZero();
    testHold();
    testBoundary();
    testRandom();
    repeat (3) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule